// File: doc/BRIEF.md
# Interline CCD timing generator

This block produces the digital drive timing for an interline-transfer CCD sensor with a complementary colour mosaic, running in a 625-line interlaced system. A sub-pixel phase counter, a pixel counter and a line counter form the timebase. Every output is decoded from the next-state value of that timebase and then registered, so each output belongs to the pixel and line shown on `pix_cnt` and `line_cnt` in the same cycle.

Horizontally it drives sync and blanking, two overlapping shift clocks, a reset-gate pulse and region flags that follow the sensor layout. The layout is a run of dummy bits, then front optical black, then effective pixels, then rear optical black. Vertically it splits the frame into two fields and marks optical-black, effective and dummy rows, where the dummy row exists only in the second field. It steps a four-phase vertical pattern once per line during blanking and issues the sensor-gate readout pulse on one line of each field. It also issues electronic-shutter substrate pulses. The `shut_lines` input sets how many lines before each readout carry no substrate pulse, and that count is the storage time.

Top module: `ccd_tg`

## Requirements
- R1: A synchronous active-high reset clears the timebase. The phase counter runs 0..DIV-1. `pix_cnt` advances once per DIV clocks and wraps after LINE_CLKS = H_BLANK+H_DUMMY+H_OBF+H_EFF+H_OBR+H_TAIL. `line_cnt` advances on each pixel wrap and wraps after FRAME lines.
- R2: `hsync` is high when pix_cnt < HSYNC_LEN. `hblank` is high when pix_cnt < H_BLANK.
- R3: For phase value q, `h1` is high when q <= DIV/2, and `h2` is high when q >= DIV/2 or q = 0. Both are therefore high at q = 0 and at q = DIV/2, and they are never both low.
- R4: `rg` is high only at q = DIV-1, which is the clock before `h1` rises.
- R5: From pixel H_BLANK onward, a line holds H_DUMMY dummy pixels, then H_OBF front black pixels, then H_EFF effective pixels, then H_OBR rear black pixels. No pixel outside these runs carries a region flag.
- R6: `field` is 0 on lines 0..F0-1 and 1 on lines F0..FRAME-1, where F0 = (FRAME+1)/2. Each field has its own line index, lif, counted from the start of that field.
- R7: Rows begin at lif = V_BLANK. In field 1 the first row is a single dummy row; field 0 has none. Then follow V_OBF/2 black rows, V_EFF/2 effective rows and V_OBR/2 black rows.
- R8: The flags are built from the horizontal and vertical zones, and at most one is high:
  - `flag_eff` needs both zones effective.
  - `flag_dum` needs either zone dummy while the other zone is active.
  - Any other pairing of active zones gives `flag_ob`.
- R9: `vphase` has bit 0 = V1 through bit 3 = V4. Its idle pattern is 4'b0011. On every line except the readout line, for pixels in [V_STEP_START, V_STEP_START+3*V_STEP_LEN), step k (0..2) shows the idle pattern rotated left k+1 times.
- R10: The readout line is lif = READ_LINE. On that line both `sg` bits are high for pixels in [SG_START, SG_START+SG_LEN), and `vphase` stays idle.
- R11: `sub` is high for pixels in [SUB_START, SUB_START+SUB_LEN) on every line that is not a readout line and that lies more than `shut_lines` lines before the next readout line. One field period of L lines therefore carries max(0, L-1-shut_lines) pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, DIV clocks per pixel |
| rst | input | 1 | Synchronous active-high reset |
| shut_lines | input | LN_W | Pulse-free lines before each readout |
| pix_cnt | output | PIX_W | Pixel position in the line |
| line_cnt | output | LN_W | Line position in the frame |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal blanking |
| field | output | 1 | Field flag |
| h1 | output | 1 | Horizontal shift clock 1 |
| h2 | output | 1 | Horizontal shift clock 2 |
| rg | output | 1 | Reset-gate pulse |
| vphase | output | 4 | Vertical transfer phases V1..V4 |
| sg | output | 2 | Readout pulses on V1 and V3 |
| sub | output | 1 | Electronic-shutter substrate pulse |
| flag_eff | output | 1 | Effective pixel |
| flag_ob | output | 1 | Optical-black pixel |
| flag_dum | output | 1 | Dummy pixel |

## Verification
A phase counter that slips shows up within one pixel period, because the overlap of `h1` and `h2` and the position of `rg` no longer follow the bench's own phase count. A pixel or line counter that is off by one moves a region boundary, a step window or the readout line. That error reaches the ports on the next line or field and is seen as early as the first misplaced flag. A wrong distance-to-readout calculation shows only as a changed number of substrate pulses per frame. Frame-long pulse counts at several `shut_lines` values, including zero and values past the field length, are what expose it.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef struct packed {
    logic dum;
    logic ob;
    logic eff;
  } region_t;

  function automatic logic in_win(input int v, input int lo, input int len);
    return (v >= lo) && (v < lo + len);
  endfunction

  // 0 = idle, 1..3 = step within the blanking window
  function automatic int step_idx(input int v, input int start, input int len);
    if (v < start || v >= start + 3 * len) return 0;
    return 1 + (v - start) / len;
  endfunction

  function automatic logic [3:0] phase_pat(input int idx);
    case (idx)
      1:       return 4'b0110;
      2:       return 4'b1100;
      3:       return 4'b1001;
      default: return 4'b0011;
    endcase
  endfunction

  // lines from ln to the next readout line (two per frame)
  function automatic int lines_to_readout(input int ln, input int rd0, input int rd1,
                                          input int frame);
    if (ln < rd0) return rd0 - ln;
    if (ln < rd1) return rd1 - ln;
    return frame - ln + rd0;
  endfunction

endpackage

// File: rtl/ccd_tg_count.sv
module ccd_tg_count #(
  parameter int DIV       = 4,
  parameter int LINE_CLKS = 964,
  parameter int FRAME     = 625,
  parameter int PH_W      = $clog2(DIV),
  parameter int PIX_W     = $clog2(LINE_CLKS),
  parameter int LN_W      = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PH_W-1:0]  ph_n,
  output logic [PIX_W-1:0] pix_n,
  output logic [LN_W-1:0]  line_n,
  output logic [PIX_W-1:0] pix,
  output logic [LN_W-1:0]  line
);
  logic [PH_W-1:0] ph;
  logic            pix_wrap;
  logic            ph_wrap;

  assign ph_wrap  = (ph == PH_W'(DIV - 1));
  assign pix_wrap = (pix == PIX_W'(LINE_CLKS - 1));

  always_comb begin
    ph_n   = ph;
    pix_n  = pix;
    line_n = line;
    if (rst) begin
      ph_n   = '0;
      pix_n  = '0;
      line_n = '0;
    end else if (ph_wrap) begin
      ph_n = '0;
      if (pix_wrap) begin
        pix_n  = '0;
        line_n = (line == LN_W'(FRAME - 1)) ? '0 : line + LN_W'(1);
      end else begin
        pix_n = pix + PIX_W'(1);
      end
    end else begin
      ph_n = ph + PH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    ph   <= ph_n;
    pix  <= pix_n;
    line <= line_n;
  end

  assert_range_R1: assert property (@(posedge clk) disable iff (rst)
    (int'(pix) < LINE_CLKS) && (int'(line) < FRAME));

  assert_pix_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !ph_wrap |=> (pix == $past(pix)));

  assert_line_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !(ph_wrap && pix_wrap) |=> (line == $past(line)));

endmodule

// File: rtl/ccd_tg_hdec.sv
module ccd_tg_hdec import ccd_tg_pkg::*; #(
  parameter int DIV       = 4,
  parameter int H_BLANK   = 120,
  parameter int HSYNC_LEN = 40,
  parameter int H_DUMMY   = 22,
  parameter int H_OBF     = 3,
  parameter int H_EFF     = 752,
  parameter int H_OBR     = 40,
  parameter int PH_W      = 2,
  parameter int PIX_W     = 10
) (
  input  logic [PH_W-1:0]  ph,
  input  logic [PIX_W-1:0] pix,
  output logic             hsync,
  output logic             hblank,
  output logic             h1,
  output logic             h2,
  output logic             rg,
  output region_t          hreg
);
  localparam int HALF  = DIV / 2;
  localparam int E_DUM = H_DUMMY;
  localparam int E_OBF = E_DUM + H_OBF;
  localparam int E_EFF = E_OBF + H_EFF;
  localparam int E_OBR = E_EFF + H_OBR;

  int p;

  always_comb begin
    p      = int'(pix) - H_BLANK;
    hsync  = int'(pix) < HSYNC_LEN;
    hblank = p < 0;
    hreg   = '0;
    if (p >= 0) begin
      if (p < E_DUM)      hreg.dum = 1'b1;
      else if (p < E_OBF) hreg.ob  = 1'b1;
      else if (p < E_EFF) hreg.eff = 1'b1;
      else if (p < E_OBR) hreg.ob  = 1'b1;
    end
    h1 = (ph <= PH_W'(HALF));
    h2 = (ph >= PH_W'(HALF)) || (ph == '0);
    rg = (ph == PH_W'(DIV - 1));
  end

endmodule

// File: rtl/ccd_tg_vdec.sv
module ccd_tg_vdec import ccd_tg_pkg::*; #(
  parameter int FRAME        = 625,
  parameter int V_BLANK      = 12,
  parameter int READ_LINE    = 4,
  parameter int V_OBF        = 12,
  parameter int V_EFF        = 582,
  parameter int V_OBR        = 2,
  parameter int V_STEP_START = 48,
  parameter int V_STEP_LEN   = 12,
  parameter int SG_START     = 50,
  parameter int SG_LEN       = 30,
  parameter int SUB_START    = 100,
  parameter int SUB_LEN      = 8,
  parameter int PIX_W        = 10,
  parameter int LN_W         = 10
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [LN_W-1:0]  line,
  input  logic [LN_W-1:0]  shut,
  output logic             field,
  output region_t          vreg,
  output logic [3:0]       vphase,
  output logic [1:0]       sg,
  output logic             sub
);
  localparam int F0    = (FRAME + 1) / 2;
  localparam int RD1   = F0 + READ_LINE;
  localparam int OBF_F = V_OBF / 2;
  localparam int EFF_F = V_EFF / 2;
  localparam int OBR_F = V_OBR / 2;

  int   ln, lif, row, px;
  logic rd_line;

  always_comb begin
    ln    = int'(line);
    px    = int'(pix);
    field = (ln >= F0);
    lif   = field ? ln - F0 : ln;
    row   = lif - V_BLANK - (field ? 1 : 0);
    vreg  = '0;
    if (field && lif == V_BLANK) vreg.dum = 1'b1;
    else if (row >= 0) begin
      if (row < OBF_F)                      vreg.ob  = 1'b1;
      else if (row < OBF_F + EFF_F)         vreg.eff = 1'b1;
      else if (row < OBF_F + EFF_F + OBR_F) vreg.ob  = 1'b1;
    end
    rd_line = (lif == READ_LINE);
    vphase  = rd_line ? phase_pat(0) : phase_pat(step_idx(px, V_STEP_START, V_STEP_LEN));
    sg      = (rd_line && in_win(px, SG_START, SG_LEN)) ? 2'b11 : 2'b00;
    sub     = !rd_line && in_win(px, SUB_START, SUB_LEN) &&
              (lines_to_readout(ln, READ_LINE, RD1, FRAME) > int'(shut));
  end

endmodule

// File: rtl/ccd_tg.sv
module ccd_tg import ccd_tg_pkg::*; #(
  parameter int DIV          = 4,
  parameter int H_BLANK      = 120,
  parameter int HSYNC_LEN    = 40,
  parameter int H_DUMMY      = 22,
  parameter int H_OBF        = 3,
  parameter int H_EFF        = 752,
  parameter int H_OBR        = 40,
  parameter int H_TAIL       = 27,
  parameter int FRAME        = 625,
  parameter int V_BLANK      = 12,
  parameter int READ_LINE    = 4,
  parameter int V_OBF        = 12,
  parameter int V_EFF        = 582,
  parameter int V_OBR        = 2,
  parameter int V_STEP_START = 48,
  parameter int V_STEP_LEN   = 12,
  parameter int SG_START     = 50,
  parameter int SG_LEN       = 30,
  parameter int SUB_START    = 100,
  parameter int SUB_LEN      = 8,
  localparam int LINE_CLKS   = H_BLANK + H_DUMMY + H_OBF + H_EFF + H_OBR + H_TAIL,
  localparam int PH_W        = $clog2(DIV),
  localparam int PIX_W       = $clog2(LINE_CLKS),
  localparam int LN_W        = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LN_W-1:0]  shut_lines,
  output logic [PIX_W-1:0] pix_cnt,
  output logic [LN_W-1:0]  line_cnt,
  output logic             hsync,
  output logic             hblank,
  output logic             field,
  output logic             h1,
  output logic             h2,
  output logic             rg,
  output logic [3:0]       vphase,
  output logic [1:0]       sg,
  output logic             sub,
  output logic             flag_eff,
  output logic             flag_ob,
  output logic             flag_dum
);
  localparam int F0 = (FRAME + 1) / 2;

  logic [PH_W-1:0]  ph_n;
  logic [PIX_W-1:0] pix_n;
  logic [LN_W-1:0]  line_n;
  logic             d_hsync, d_hblank, d_h1, d_h2, d_rg, d_field, d_sub;
  logic [3:0]       d_vphase;
  logic [1:0]       d_sg;
  region_t          hreg, vreg, rmix;

  ccd_tg_count #(.DIV(DIV), .LINE_CLKS(LINE_CLKS), .FRAME(FRAME),
                 .PH_W(PH_W), .PIX_W(PIX_W), .LN_W(LN_W)) u_count (
    .clk(clk), .rst(rst), .ph_n(ph_n), .pix_n(pix_n), .line_n(line_n),
    .pix(pix_cnt), .line(line_cnt));

  ccd_tg_hdec #(.DIV(DIV), .H_BLANK(H_BLANK), .HSYNC_LEN(HSYNC_LEN), .H_DUMMY(H_DUMMY),
                .H_OBF(H_OBF), .H_EFF(H_EFF), .H_OBR(H_OBR),
                .PH_W(PH_W), .PIX_W(PIX_W)) u_hdec (
    .ph(ph_n), .pix(pix_n), .hsync(d_hsync), .hblank(d_hblank),
    .h1(d_h1), .h2(d_h2), .rg(d_rg), .hreg(hreg));

  ccd_tg_vdec #(.FRAME(FRAME), .V_BLANK(V_BLANK), .READ_LINE(READ_LINE), .V_OBF(V_OBF),
                .V_EFF(V_EFF), .V_OBR(V_OBR), .V_STEP_START(V_STEP_START),
                .V_STEP_LEN(V_STEP_LEN), .SG_START(SG_START), .SG_LEN(SG_LEN),
                .SUB_START(SUB_START), .SUB_LEN(SUB_LEN),
                .PIX_W(PIX_W), .LN_W(LN_W)) u_vdec (
    .pix(pix_n), .line(line_n), .shut(shut_lines), .field(d_field), .vreg(vreg),
    .vphase(d_vphase), .sg(d_sg), .sub(d_sub));

  // combine horizontal and vertical zones into one pixel class
  always_comb begin
    rmix.eff = hreg.eff & vreg.eff;
    rmix.ob  = (hreg.ob & (vreg.ob | vreg.eff)) | (hreg.eff & vreg.ob);
    rmix.dum = (hreg.dum & (vreg.dum | vreg.ob | vreg.eff)) |
               (vreg.dum & (hreg.ob | hreg.eff));
  end

  always_ff @(posedge clk) begin
    hsync    <= d_hsync;
    hblank   <= d_hblank;
    field    <= d_field;
    h1       <= d_h1;
    h2       <= d_h2;
    rg       <= d_rg;
    vphase   <= d_vphase;
    sg       <= d_sg;
    sub      <= d_sub;
    flag_eff <= rmix.eff;
    flag_ob  <= rmix.ob;
    flag_dum <= rmix.dum;
  end

  assert_sync_in_blank_R2: assert property (@(posedge clk) disable iff (rst)
    hsync |-> hblank);

  assert_hclk_cover_R3: assert property (@(posedge clk) disable iff (rst)
    h1 || h2);

  assert_rg_before_h1_R4: assert property (@(posedge clk) disable iff (rst)
    rg |-> (h2 && !h1));

  assert_flags_outside_blank_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_eff || flag_ob || flag_dum) |-> !hblank);

  assert_field_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (field != $past(field)) |-> (line_cnt == '0 || int'(line_cnt) == F0));

  assert_region_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_eff, flag_ob, flag_dum}));

  assert_vphase_pair_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(vphase) == 2);

  assert_sg_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (sg != 2'b00) |-> (hblank && vphase == 4'b0011));

  assert_sub_in_blank_R11: assert property (@(posedge clk) disable iff (rst)
    sub |-> (hblank && sg == 2'b00));

endmodule

// File: tb/ccd_tg_bench.sv
module ccd_tg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4, H_BLANK = 24, HSYNC_LEN = 4, H_DUMMY = 2, H_OBF = 1;
  localparam int H_EFF = 4, H_OBR = 2, H_TAIL = 3;
  localparam int FRAME = 25, V_BLANK = 4, READ_LINE = 1, V_OBF = 2, V_EFF = 10, V_OBR = 2;
  localparam int V_STEP_START = 4, V_STEP_LEN = 3, SG_START = 5, SG_LEN = 6;
  localparam int SUB_START = 18, SUB_LEN = 3;
  localparam int LINE_CLKS = H_BLANK + H_DUMMY + H_OBF + H_EFF + H_OBR + H_TAIL;
  localparam int F0 = (FRAME + 1) / 2;
  localparam int F1 = FRAME - F0;
  localparam int PIX_W = $clog2(LINE_CLKS);
  localparam int LN_W = $clog2(FRAME);
  localparam int FRAME_CLKS = FRAME * LINE_CLKS * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LN_W-1:0] shut_lines = '0;
  logic [PIX_W-1:0] pix_cnt;
  logic [LN_W-1:0] line_cnt;
  logic hsync, hblank, field, h1, h2, rg, sub, flag_eff, flag_ob, flag_dum;
  logic [3:0] vphase;
  logic [1:0] sg;

  int n_checks = 0, n_fail = 0;
  int m_ph = 0, m_pix = 0, m_line = 0, m_shut = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_tg #(.DIV(DIV), .H_BLANK(H_BLANK), .HSYNC_LEN(HSYNC_LEN), .H_DUMMY(H_DUMMY),
           .H_OBF(H_OBF), .H_EFF(H_EFF), .H_OBR(H_OBR), .H_TAIL(H_TAIL), .FRAME(FRAME),
           .V_BLANK(V_BLANK), .READ_LINE(READ_LINE), .V_OBF(V_OBF), .V_EFF(V_EFF),
           .V_OBR(V_OBR), .V_STEP_START(V_STEP_START), .V_STEP_LEN(V_STEP_LEN),
           .SG_START(SG_START), .SG_LEN(SG_LEN), .SUB_START(SUB_START),
           .SUB_LEN(SUB_LEN)) u_ccd_tg (
    .clk(clk), .rst(rst), .shut_lines(shut_lines), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .hsync(hsync), .hblank(hblank), .field(field), .h1(h1), .h2(h2), .rg(rg),
    .vphase(vphase), .sg(sg), .sub(sub), .flag_eff(flag_eff), .flag_ob(flag_ob),
    .flag_dum(flag_dum));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d pix %0d)",
               tag, what, act, exp, m_line, m_pix);
    end
  endtask

  // ---- reference model, written from the requirements ----
  function automatic int lif_of(input int ln);
    return (ln >= F0) ? ln - F0 : ln;
  endfunction

  // 0 none, 1 dummy, 2 black, 3 effective
  function automatic int hzone();
    int q;
    q = m_pix - H_BLANK;
    if (q < 0) return 0;
    if (q < H_DUMMY) return 1;
    q -= H_DUMMY;
    if (q < H_OBF) return 2;
    q -= H_OBF;
    if (q < H_EFF) return 3;
    q -= H_EFF;
    if (q < H_OBR) return 2;
    return 0;
  endfunction

  function automatic int vzone();
    int r;
    r = lif_of(m_line) - V_BLANK;
    if (r < 0) return 0;
    if (m_line >= F0) begin
      if (r == 0) return 1;
      r = r - 1;
    end
    if (r < V_OBF/2) return 2;
    r -= V_OBF/2;
    if (r < V_EFF/2) return 3;
    r -= V_EFF/2;
    if (r < V_OBR/2) return 2;
    return 0;
  endfunction

  function automatic int exp_class(); // 0 none 1 dum 2 ob 3 eff
    int hz, vz;
    hz = hzone(); vz = vzone();
    if (hz == 0 || vz == 0) return 0;
    if (hz == 1 || vz == 1) return 1;
    if (hz == 3 && vz == 3) return 3;
    return 2;
  endfunction

  function automatic bit is_rd(input int ln);
    return lif_of(ln) == READ_LINE;
  endfunction

  function automatic int exp_vphase();
    logic [3:0] pat;
    int k;
    pat = 4'b0011;
    if (is_rd(m_line) || m_pix < V_STEP_START || m_pix >= V_STEP_START + 3*V_STEP_LEN)
      return int'(pat);
    k = (m_pix - V_STEP_START) / V_STEP_LEN;
    for (int i = 0; i <= k; i++) pat = {pat[2:0], pat[3]};
    return int'(pat);
  endfunction

  function automatic int exp_sub();
    int d;
    d = 0;
    if (is_rd(m_line)) return 0;
    if (m_pix < SUB_START || m_pix >= SUB_START + SUB_LEN) return 0;
    for (int k = 1; k <= FRAME; k++)
      if (d == 0 && is_rd((m_line + k) % FRAME)) d = k;
    return (d > m_shut) ? 1 : 0;
  endfunction

  task automatic compare_all();
    int cls;
    cls = exp_class();
    chk("R1", "pix_cnt", int'(pix_cnt), m_pix);
    chk("R1", "line_cnt", int'(line_cnt), m_line);
    chk("R2", "hsync", int'(hsync), int'(m_pix < HSYNC_LEN));
    chk("R2", "hblank", int'(hblank), int'(m_pix < H_BLANK));
    chk("R3", "h1", int'(h1), int'(m_ph <= DIV/2));
    chk("R3", "h2", int'(h2), int'(m_ph >= DIV/2 || m_ph == 0));
    chk("R4", "rg", int'(rg), int'(m_ph == DIV-1));
    chk("R6", "field", int'(field), int'(m_line >= F0));
    chk("R8", "flag_eff", int'(flag_eff), int'(cls == 3));
    chk("R8", "flag_ob", int'(flag_ob), int'(cls == 2));
    chk("R8", "flag_dum", int'(flag_dum), int'(cls == 1));
    chk("R9", "vphase", int'(vphase), exp_vphase());
    chk("R10", "sg", int'(sg),
        (is_rd(m_line) && m_pix >= SG_START && m_pix < SG_START + SG_LEN) ? 3 : 0);
    chk("R11", "sub", int'(sub), exp_sub());
  endtask

  task automatic step();
    logic r;
    int s;
    r = rst;
    s = int'(shut_lines);
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      m_ph = 0; m_pix = 0; m_line = 0;
    end else if (m_ph == DIV-1) begin
      m_ph = 0;
      if (m_pix == LINE_CLKS-1) begin
        m_pix = 0;
        m_line = (m_line + 1) % FRAME;
      end else m_pix++;
    end else m_ph++;
    m_shut = s;
    compare_all();
  endtask

  task automatic align_frame();
    while (!(m_ph == 0 && m_pix == 0 && m_line == 0)) step();
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    rst = 1'b1;
    repeat (4) step();
    chk("R1", "reset pix_cnt", int'(pix_cnt), 0);
    chk("R1", "reset line_cnt", int'(line_cnt), 0);
    chk("R1", "reset field", int'(field), 0);
    chk("R1", "reset hsync/hblank", int'({hsync, hblank}), 3);
    chk("R1", "reset h1/h2/rg", int'({h1, h2, rg}), 6);
    chk("R1", "reset vphase", int'(vphase), 3);
    chk("R1", "reset flags", int'({flag_eff, flag_ob, flag_dum, sg, sub}), 0);
    rst = 1'b0;
  endtask

  task automatic t_hclocks();
    int rg_cnt, gap;
    rg_cnt = 0; gap = 0;
    repeat (LINE_CLKS * DIV) begin
      step();
      if (rg) rg_cnt++;
      if (!h1 && !h2) gap++;
    end
    chk("R3", "clocks both low", gap, 0);
    chk("R4", "rg pulses per line", rg_cnt, LINE_CLKS);
  endtask

  task automatic t_frame();
    int dum_rows [2];
    int eff_c, ob_c, dum_c, sg_c;
    dum_rows[0] = 0; dum_rows[1] = 0;
    eff_c = 0; ob_c = 0; dum_c = 0; sg_c = 0;
    align_frame();
    repeat (FRAME_CLKS) begin
      step();
      if (m_ph == 0 && m_pix == H_BLANK + H_DUMMY && flag_dum) dum_rows[m_line >= F0]++;
      if (m_line == V_BLANK + V_OBF/2) begin
        eff_c += int'(flag_eff); ob_c += int'(flag_ob); dum_c += int'(flag_dum);
      end
      if (sg == 2'b11) sg_c++;
    end
    chk("R7", "dummy rows in field 0", dum_rows[0], 0);
    chk("R7", "dummy rows in field 1", dum_rows[1], 1);
    chk("R5", "effective clocks in a line", eff_c, H_EFF * DIV);
    chk("R5", "black clocks in a line", ob_c, (H_OBF + H_OBR) * DIV);
    chk("R5", "dummy clocks in a line", dum_c, H_DUMMY * DIV);
    chk("R10", "readout clocks per frame", sg_c, 2 * SG_LEN * DIV);
  endtask

  task automatic t_shutter(input int s);
    int pulses, expv;
    logic prev;
    shut_lines = LN_W'(s);
    align_frame();
    pulses = 0;
    prev = sub;
    repeat (FRAME_CLKS) begin
      step();
      if (sub && !prev) pulses++;
      prev = sub;
    end
    expv = ((F0 - 1 - s) > 0 ? F0 - 1 - s : 0) + ((F1 - 1 - s) > 0 ? F1 - 1 - s : 0);
    chk("R11", $sformatf("substrate pulses per frame, shut=%0d", s), pulses, expv);
  endtask

  task automatic t_midreset();
    repeat (LINE_CLKS * DIV * 3 + 7) step();
    rst = 1'b1;
    step();
    chk("R1", "mid-run reset pix_cnt", int'(pix_cnt), 0);
    chk("R1", "mid-run reset line_cnt", int'(line_cnt), 0);
    rst = 1'b0;
    repeat (DIV) step();
    chk("R1", "pixel after reset", int'(pix_cnt), 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_hclocks();
    t_frame();
    t_shutter(0);
    t_shutter(3);
    t_shutter(10);
    t_shutter(20);
    t_midreset();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule